// File: doc/BRIEF.md
# Variable Mark-Ratio PRBS Generator

This block produces a serial pseudo-random test stream from a Fibonacci linear feedback shift register whose order is chosen at run time from seven maximal-length polynomials. The plain register output has balanced density: one more one than zero per period. The block can shift this density down by ANDing two or three register stages, and up by inverting that product. The AND can take its stages from adjacent positions or from positions three apart.

A strobe marks the first bit of each period, so a receiver or a scope trigger can align to the pattern. A change of density or tap spacing is held back until the next period starts, so each period is built with one setting only. A change of polynomial restarts the pattern from its seed at once.

Top module: `prbs_mark_gen`

## Requirements
- R1: During synchronous reset `dout` and `sop` are 0 and the register is loaded with the seed (all ones over the selected order). The first enabled clock after reset emits the first bit of a pattern, with `sop` = 1 and `dout` = 1 in balanced mode.
- R2: `sop` is high for exactly one output bit per period, and consecutive `sop` bits are 2^n-1 enabled outputs apart. Order codes on `poly_sel` are: 0 selects n=7, 1 selects 9, 2 selects 11, 3 selects 15, 4 selects 20, 5 selects 23, 6 selects 31, and 7 selects 7.
- R3: In balanced mode the stream p obeys p[m] = p[m-n] XOR p[m-k] with (n,k) = (7,6), (9,5), (11,9), (15,14), (20,3), (23,18), (31,28), and the first n bits after `sop` are ones.
- R4: In balanced mode (`ratio_sel` = 0) one period holds 2^(n-1) ones. For n=7 the longest run of ones is 7 and the longest run of zeros is 6.
- R5: `ratio_sel` = 1 (quarter density) gives 2^(n-2) ones per period, and `ratio_sel` = 2 (eighth density) gives 2^(n-3) ones, for either spacing. Codes 5 to 7 act as balanced mode.
- R6: `ratio_sel` = 3 gives the complement of quarter density, 2^n-1-2^(n-2) ones per period. `ratio_sel` = 4 gives the complement of eighth density, 2^n-1-2^(n-3) ones per period.
- R7: `spacing_sel` = 0 ANDs adjacent stages and `spacing_sel` = 1 ANDs stages three apart. For n=7 at quarter density, spacing 0 never yields the bit triple 1,0,1 in a period, while spacing 1 does.
- R8: While `en` is 0 the register does not advance, `dout` holds its last value and `sop` is 0. When `en` returns, the stream resumes with the next bit of the sequence.
- R9: A change of `poly_sel` reloads the seed at the next clock, giving one output cycle with `dout` = 0 and `sop` = 0. The next enabled output is a new pattern start of the new order.
- R10: A change of `ratio_sel` or `spacing_sel` takes effect only at the next `sop` bit, so the period in progress keeps its old setting throughout.
- R11: The register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one bit per clock when high |
| poly_sel | input | 3 | Polynomial order code |
| ratio_sel | input | 3 | Mark density code |
| spacing_sel | input | 1 | Tap spacing: 0 adjacent, 1 three apart |
| dout | output | 1 | Serial pattern bit |
| sop | output | 1 | High on the first bit of each period |

## Verification
The hardest case to reach is a setting change that lands in the middle of a period. The deferred update shows only as an unchanged ones count for that period, followed by a changed count in the next one. The bench aligns to a pattern start, counts off ten bits, switches to the inverted eighth density mid-period, and then counts both the interrupted period and the following one bit by bit. A similar mid-period stop of `en` and a mid-period polynomial change are checked against an independent recurrence model of the sequence.

// File: rtl/prbs_mr_pkg.sv
package prbs_mr_pkg;

    localparam int unsigned LFSR_W  = 31;
    localparam int unsigned N_CODES = 8;
    localparam int unsigned IDX_W   = $clog2(LFSR_W + 1);

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        ORD_7  = 3'd0,
        ORD_9  = 3'd1,
        ORD_11 = 3'd2,
        ORD_15 = 3'd3,
        ORD_20 = 3'd4,
        ORD_23 = 3'd5,
        ORD_31 = 3'd6,
        ORD_7B = 3'd7
    } order_e;

    typedef enum logic [2:0] {
        MR_HALF    = 3'd0,
        MR_QUARTER = 3'd1,
        MR_EIGHTH  = 3'd2,
        MR_3QUART  = 3'd3,
        MR_7EIGHTH = 3'd4
    } ratio_e;

    typedef enum logic {
        SP_ADJ   = 1'b0,
        SP_THREE = 1'b1
    } spacing_e;

    typedef struct packed {
        ratio_e   ratio;
        spacing_e spacing;
    } mark_cfg_t;

    // register length for an order code
    function automatic idx_t order_len(logic [2:0] code);
        case (code)
            3'd1:    return idx_t'(9);
            3'd2:    return idx_t'(11);
            3'd3:    return idx_t'(15);
            3'd4:    return idx_t'(20);
            3'd5:    return idx_t'(23);
            3'd6:    return idx_t'(31);
            default: return idx_t'(7);
        endcase
    endfunction

    // inner feedback exponent for an order code
    function automatic idx_t order_tap(logic [2:0] code);
        case (code)
            3'd1:    return idx_t'(5);
            3'd2:    return idx_t'(9);
            3'd3:    return idx_t'(14);
            3'd4:    return idx_t'(3);
            3'd5:    return idx_t'(18);
            3'd6:    return idx_t'(28);
            default: return idx_t'(6);
        endcase
    endfunction

    // all ones over the active stages; doubles as the state mask
    function automatic lfsr_t seed_of(logic [2:0] code);
        return {LFSR_W{1'b1}} >> (idx_t'(LFSR_W) - order_len(code));
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_mr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   load,
    input  order_e order,
    output lfsr_t  state,
    output logic   at_seed
);

    lfsr_t               state_q;
    lfsr_t               seed;
    lfsr_t               nxt;
    logic [N_CODES-1:0]  fb_cand;
    logic                fb;

    // one feedback XOR per order code, picked by the select
    for (genvar g = 0; g < N_CODES; g++) begin : g_fb
        localparam int HI  = int'(order_len(3'(g))) - 1;
        localparam int TAP = int'(order_tap(3'(g))) - 1;
        assign fb_cand[g] = state_q[HI] ^ state_q[TAP];
    end

    assign seed    = seed_of(order);
    assign fb      = fb_cand[order];
    assign nxt     = ((state_q << 1) | lfsr_t'(fb)) & seed;
    assign at_seed = (state_q == seed);
    assign state   = state_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            state_q <= seed;
        else if (step)
            state_q <= nxt;
    end

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/prbs_mark_shaper.sv
module prbs_mark_shaper
    import prbs_mr_pkg::*;
(
    input  lfsr_t     state,
    input  order_e    order,
    input  mark_cfg_t cfg,
    output logic      bit_o
);

    lfsr_t aligned;
    idx_t  i0;
    idx_t  i1;
    idx_t  i2;
    logic  t0;
    logic  t1;
    logic  t2;
    logic  and2;
    logic  and3;

    // move the output stage to the top bit so tap positions are fixed
    assign aligned = state << (idx_t'(LFSR_W) - order_len(order));
    assign i0      = idx_t'(LFSR_W - 1);

    always_comb begin
        if (cfg.spacing == SP_THREE) begin
            i1 = i0 - idx_t'(3);
            i2 = i0 - idx_t'(6);
        end else begin
            i1 = i0 - idx_t'(1);
            i2 = i0 - idx_t'(2);
        end
    end

    assign t0   = aligned[i0];
    assign t1   = aligned[i1];
    assign t2   = aligned[i2];
    assign and2 = t0 & t1;
    assign and3 = and2 & t2;

    always_comb begin
        case (cfg.ratio)
            MR_QUARTER: bit_o = and2;
            MR_EIGHTH:  bit_o = and3;
            MR_3QUART:  bit_o = ~and2;
            MR_7EIGHTH: bit_o = ~and3;
            default:    bit_o = t0;
        endcase
    end

endmodule

// File: rtl/prbs_mark_gen.sv
module prbs_mark_gen
    import prbs_mr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] poly_sel,
    input  logic [2:0] ratio_sel,
    input  logic       spacing_sel,
    output logic       dout,
    output logic       sop
);

    order_e    cur_order;
    order_e    req_order;
    order_e    ord_use;
    logic      reload;
    logic      step;
    lfsr_t     state;
    logic      at_seed;
    mark_cfg_t pend_cfg;
    mark_cfg_t act_cfg;
    mark_cfg_t use_cfg;
    logic      shaped;
    logic      dout_q;
    logic      sop_q;

    assign req_order = order_e'(poly_sel);
    assign reload    = (req_order != cur_order);
    assign ord_use   = (rst || reload) ? req_order : cur_order;
    assign step      = en && !reload;

    assign pend_cfg.ratio   = ratio_e'(ratio_sel);
    assign pend_cfg.spacing = spacing_e'(spacing_sel);
    // a new setting is adopted only on the first bit of a period
    assign use_cfg          = at_seed ? pend_cfg : act_cfg;

    prbs_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .load    (reload),
        .order   (ord_use),
        .state   (state),
        .at_seed (at_seed)
    );

    prbs_mark_shaper u_shape (
        .state (state),
        .order (cur_order),
        .cfg   (use_cfg),
        .bit_o (shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_order <= req_order;
            act_cfg   <= pend_cfg;
            dout_q    <= 1'b0;
            sop_q     <= 1'b0;
        end else if (reload) begin
            cur_order <= req_order;
            dout_q    <= 1'b0;
            sop_q     <= 1'b0;
        end else if (step) begin
            act_cfg   <= use_cfg;
            dout_q    <= shaped;
            sop_q     <= at_seed;
        end else begin
            sop_q     <= 1'b0;
        end
    end

    assign dout = dout_q;
    assign sop  = sop_q;

    // R2
    sop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sop_q |=> !sop_q);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> ($stable(dout_q) && !sop_q));

    // R9
    reload_seed_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(reload) && !reload) |-> at_seed);

    // R10
    cfg_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_cfg) |-> $past(at_seed && step));

endmodule

// File: tb/sim_prbs_mark_gen.sv
`timescale 1ns/1ps
module sim_prbs_mark_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [2:0] poly_sel = 3'd0;
    logic [2:0] ratio_sel = 3'd0;
    logic       spacing_sel = 1'b0;
    logic       dout;
    logic       sop;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ref_bits [0:511];

    always #2.5 clk = ~clk;

    prbs_mark_gen u0 (
        .clk(clk), .rst(rst), .en(en), .poly_sel(poly_sel),
        .ratio_sel(ratio_sel), .spacing_sel(spacing_sel),
        .dout(dout), .sop(sop)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    task automatic step_read();
        @(negedge clk);
    endtask

    task automatic seek_sop();
        int i;
        step_read();
        i = 0;
        while (!sop && i < 70000) begin
            step_read();
            i++;
        end
    endtask

    // current sample is a pattern start; stops on the next start
    task automatic run_period(output int len, output int ones,
                              output int r1, output int r0, output bit has101);
        int run1;
        int run0;
        logic [2:0] hist;
        len = 0; ones = 0; r1 = 0; r0 = 0; has101 = 0;
        run1 = 0; run0 = 0; hist = 3'b000;
        for (int i = 0; i < 70000; i++) begin
            if (i != 0 && sop) break;
            len++;
            ones += int'(dout);
            hist = {hist[1:0], dout};
            if (len >= 3 && hist == 3'b101) has101 = 1;
            if (dout) begin run1++; run0 = 0; end
            else      begin run0++; run1 = 0; end
            if (run1 > r1) r1 = run1;
            if (run0 > r0) r0 = run0;
            step_read();
        end
    endtask

    task automatic build_model(int n, int k);
        for (int m = 0; m < 512; m++)
            ref_bits[m] = (m < n) ? 1'b1 : (ref_bits[m-n] ^ ref_bits[m-k]);
    endtask

    function automatic int ord_n(int code);
        case (code)
            1: return 9;  2: return 11; 3: return 15; 4: return 20;
            5: return 23; 6: return 31; default: return 7;
        endcase
    endfunction

    function automatic int ord_k(int code);
        case (code)
            1: return 5;  2: return 9;  3: return 14; 4: return 3;
            5: return 18; 6: return 28; default: return 6;
        endcase
    endfunction

    task automatic t_reset();
        rst = 1'b1; en = 1'b0;
        repeat (3) step_read();
        rst = 1'b0;
        step_read();
        check(dout == 1'b0 && sop == 1'b0, "R1", "outputs after reset", {dout, sop}, 0);
        en = 1'b1;
        step_read();
        check(sop == 1'b1, "R1", "sop on first enabled bit", sop, 1);
        check(dout == 1'b1, "R1", "first bit is one", dout, 1);
    endtask

    task automatic t_balanced(int code);
        int len, ones, r1, r0;
        bit h;
        int n;
        n = ord_n(code);
        poly_sel = 3'(code); ratio_sel = 3'd0; spacing_sel = 1'b0;
        seek_sop();
        run_period(len, ones, r1, r0, h);
        check(len == (1 << n) - 1, "R2", "period length", len, (1 << n) - 1);
        check(ones == (1 << (n - 1)), "R4", "balanced ones", ones, 1 << (n - 1));
        if (n == 7) begin
            check(r1 == 7, "R4", "longest ones run", r1, 7);
            check(r0 == 6, "R4", "longest zeros run", r0, 6);
        end
    endtask

    task automatic t_model(int code);
        int errs;
        poly_sel = 3'(code); ratio_sel = 3'd0;
        build_model(ord_n(code), ord_k(code));
        seek_sop();
        errs = 0;
        for (int i = 0; i < 200; i++) begin
            if (dout != ref_bits[i]) errs++;
            step_read();
        end
        check(errs == 0, "R3", $sformatf("sequence order %0d", ord_n(code)), errs, 0);
    endtask

    task automatic t_ratio(int code, int ratio, bit sp, int exp_ones, int want101);
        int len, ones, r1, r0;
        bit h;
        poly_sel = 3'(code); ratio_sel = 3'(ratio); spacing_sel = sp;
        seek_sop();
        run_period(len, ones, r1, r0, h);
        check(ones == exp_ones, (ratio >= 3) ? "R6" : "R5",
              $sformatf("ones n=%0d ratio=%0d sp=%0d", ord_n(code), ratio, sp), ones, exp_ones);
        if (want101 >= 0)
            check(int'(h) == want101, "R7", "101 presence", int'(h), want101);
    endtask

    task automatic t_defer();
        int len, ones, r1, r0;
        bit h;
        int cnt;
        poly_sel = 3'd0; ratio_sel = 3'd0; spacing_sel = 1'b0;
        seek_sop();
        cnt = int'(dout);
        for (int i = 1; i < 127; i++) begin
            if (i == 10) ratio_sel = 3'd4;
            step_read();
            cnt += int'(dout);
        end
        step_read();
        check(cnt == 64, "R10", "period with mid change keeps old ratio", cnt, 64);
        check(sop == 1'b1, "R10", "next start reached", sop, 1);
        run_period(len, ones, r1, r0, h);
        check(ones == 111, "R10", "new ratio from next start", ones, 111);
    endtask

    task automatic t_enable();
        int errs;
        poly_sel = 3'd0; ratio_sel = 3'd0;
        build_model(7, 6);
        seek_sop();
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            if (dout != ref_bits[i]) errs++;
            if (i < 7) step_read();
        end
        en = 1'b0;
        for (int j = 0; j < 4; j++) begin
            step_read();
            check(dout == ref_bits[7] && sop == 1'b0, "R8", "held while disabled",
                  {dout, sop}, {ref_bits[7], 1'b0});
        end
        en = 1'b1;
        for (int i = 8; i < 40; i++) begin
            step_read();
            if (dout != ref_bits[i]) errs++;
        end
        check(errs == 0, "R8", "resume continues sequence", errs, 0);
    endtask

    task automatic t_reload();
        int errs;
        poly_sel = 3'd0; ratio_sel = 3'd0;
        seek_sop();
        repeat (20) step_read();
        poly_sel = 3'd1;
        build_model(9, 5);
        step_read();
        check(dout == 1'b0 && sop == 1'b0, "R9", "reload cycle output", {dout, sop}, 0);
        step_read();
        check(sop == 1'b1, "R9", "restart after polynomial change", sop, 1);
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            if (dout != ref_bits[i]) errs++;
            step_read();
        end
        check(errs == 0, "R9", "new order sequence", errs, 0);
    endtask

    initial begin
        t_reset();
        t_balanced(0);
        t_balanced(1);
        t_balanced(2);
        t_balanced(3);
        t_model(0);
        t_model(4);
        t_model(5);
        t_model(6);
        t_ratio(0, 1, 1'b0, 32, 0);
        t_ratio(0, 1, 1'b1, 32, 1);
        t_ratio(0, 2, 1'b0, 16, -1);
        t_ratio(0, 2, 1'b1, 16, -1);
        t_ratio(0, 3, 1'b0, 95, -1);
        t_ratio(0, 4, 1'b1, 111, -1);
        t_ratio(0, 6, 1'b0, 64, -1);
        t_ratio(1, 1, 1'b1, 128, -1);
        t_ratio(1, 2, 1'b0, 64, -1);
        t_defer();
        t_enable();
        t_reload();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule